// File: doc/BRIEF.md
# Sector-Addressed RAM Disk Controller

This block makes a large battery-backed static RAM look like a sector disk. The CPU sees four byte registers. One is a data port, two hold a 16-bit logical sector number, and one is a command/status register. An internal byte counter points into the selected sector and advances after every data-port access. A whole sector therefore moves by reading or writing the same address repeatedly, which suits both programmed I/O and a burst DMA engine.

The RAM address is the sector number concatenated with the in-sector counter. The counter width is a parameter: 8 bits gives 256-byte sectors and 16 MB of reach, and 9 bits gives 512-byte sectors. The command register carries a write-protect bit. A protected data write still advances the counter but never strobes the RAM, and it leaves a sticky error flag behind.

Each CPU access is a one-cycle `bus_req` pulse, taken only in state IDLE. It ends with a one-cycle `bus_ack` in state ACK. The access state machine has four states and these transitions:
- IDLE→WR: an unprotected data write.
- IDLE→RD: a data read.
- IDLE→ACK: a register access or a protected data write.
- WR→ACK and RD→ACK: always.
- ACK→IDLE: always.

Top module: `rdsk_top`

## Requirements
- R1: Register offsets are 0 data port, 1 sector number high byte, 2 sector number low byte, 3 command/status. Both sector bytes read back as written.
- R2: A data write stores `bus_wdat` at RAM address {sector, counter}. A data read returns the byte at that address. `ram_we` and `ram_oe` are never high together.
- R3: The counter advances by one at the end of each data access, so consecutive reads or writes stream bytes 0..N-1 of the sector.
- R4: Writing either sector-number byte clears the counter to 0.
- R5: The counter wraps from N-1 to 0 without carrying into the sector number. Status bit 2 (sector complete) is set by that wrap. It is cleared by a sector-number write or by the next data access.
- R6: Command bit 0 written as 1 sets write protect, which reads back in status bit 0. A data write while it is set produces no `ram_we` but still advances the counter.
- R7: A protected data write sets status bit 1 (error). The bit stays set until a command write with bit 1 = 1 clears it.
- R8: `bus_ack` comes 1 cycle after an accepted request for register accesses and protected writes, and 2 cycles after for RAM data accesses. Read data is valid while `bus_ack` is high.
- R9: With `SECT_BITS` = 9 the sector is 512 bytes. The address is then {sector, counter[8:0]}, and sector complete is set only after 512 accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | One-cycle access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 2 | Register offset |
| bus_wdat | input | 8 | Write data |
| bus_ack | output | 1 | Access complete |
| bus_rdat | output | 8 | Read data, valid with bus_ack |
| ram_addr | output | 16+SECT_BITS | RAM byte address {sector, counter} |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| ram_we | output | 1 | RAM write strobe |
| ram_oe | output | 1 | RAM output enable |

## Verification
An access is accepted at the clock edge where `bus_req` is high in IDLE. `bus_ack` is then due one cycle later for register accesses and protected writes, and two cycles later for RAM accesses. The bench samples on falling edges and counts the cycles from the accepting edge to the first falling edge where `bus_ack` is high. It takes read data only at that point. It compares the count with 1 or 2 wherever R8 is checked.

The RAM model reads on the falling edge while `ram_oe` is high and writes on the rising edge while `ram_we` is high. Data reads therefore see the address that the counter held during state RD. Every readback is compared with a reference array that the bench keeps from its own writes.

// File: rtl/rdsk_pkg.sv
`timescale 1ns/1ps
package rdsk_pkg;
    localparam int SNUM_BITS = 16;

    localparam logic [1:0] OFS_DATA = 2'd0;
    localparam logic [1:0] OFS_SHI  = 2'd1;
    localparam logic [1:0] OFS_SLO  = 2'd2;
    localparam logic [1:0] OFS_CMD  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WR   = 2'd1,
        ST_RD   = 2'd2,
        ST_ACK  = 2'd3
    } acc_state_t;
endpackage

// File: rtl/rdsk_fsm.sv
`timescale 1ns/1ps
module rdsk_fsm
    import rdsk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       we,
    input  logic [1:0] sel,
    input  logic       wp,
    output logic       accept,
    output logic       reg_wr,
    output logic       reg_rd,
    output logic       blk_wr,
    output logic       step,
    output logic       cap,
    output logic       ram_we,
    output logic       ram_oe,
    output logic       ack
);
    acc_state_t state, nxt;
    logic       is_data;

    assign is_data = (sel == OFS_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt    = state;
        accept = 1'b0;
        reg_wr = 1'b0;
        reg_rd = 1'b0;
        blk_wr = 1'b0;
        step   = 1'b0;
        cap    = 1'b0;
        ram_we = 1'b0;
        ram_oe = 1'b0;
        ack    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    if (!is_data) begin
                        reg_wr = we;
                        reg_rd = !we;
                        nxt    = ST_ACK;
                    end else if (!we) begin
                        nxt    = ST_RD;
                    end else if (wp) begin
                        blk_wr = 1'b1;
                        step   = 1'b1;
                        nxt    = ST_ACK;
                    end else begin
                        nxt    = ST_WR;
                    end
                end
            end
            ST_WR: begin
                ram_we = 1'b1;
                step   = 1'b1;
                nxt    = ST_ACK;
            end
            ST_RD: begin
                ram_oe = 1'b1;
                cap    = 1'b1;
                step   = 1'b1;
                nxt    = ST_ACK;
            end
            ST_ACK: begin
                ack = 1'b1;
                nxt = ST_IDLE;
            end
        endcase
    end

    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_we && ram_oe)); // R2
    AST_WE_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> ack); // R8
    AST_PROT_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req && we && is_data && wp) |=> !ram_we); // R6
endmodule

// File: rtl/rdsk_regs.sv
`timescale 1ns/1ps
module rdsk_regs
    import rdsk_pkg::*;
#(
    parameter int SECT_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic                 blk_wr,
    input  logic                 step,
    input  logic                 cap,
    input  logic [1:0]           sel,
    input  logic [7:0]           wdat,
    input  logic [7:0]           ram_rdata,
    output logic [SNUM_BITS-1:0] sector,
    output logic [SECT_BITS-1:0] cnt,
    output logic                 wp,
    output logic [7:0]           wq,
    output logic [7:0]           rq
);
    localparam logic [SECT_BITS-1:0] CNT_MAX = {SECT_BITS{1'b1}};

    logic       err, cmp;
    logic       sec_wr, cmd_wr;
    logic [7:0] reg_view;

    assign sec_wr = reg_wr && (sel == OFS_SHI || sel == OFS_SLO);
    assign cmd_wr = reg_wr && (sel == OFS_CMD);

    always_comb begin
        unique case (sel)
            OFS_SHI: reg_view = sector[15:8];
            OFS_SLO: reg_view = sector[7:0];
            OFS_CMD: reg_view = {5'b0, cmp, err, wp};
            default: reg_view = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sector <= '0;
            cnt    <= '0;
            wp     <= 1'b0;
            err    <= 1'b0;
            cmp    <= 1'b0;
            wq     <= 8'h00;
            rq     <= 8'h00;
        end else begin
            if (accept) wq <= wdat;
            if (sec_wr) begin
                if (sel == OFS_SHI) sector[15:8] <= wdat;
                else                sector[7:0]  <= wdat;
                cnt <= '0;
                cmp <= 1'b0;
            end
            if (cmd_wr) begin
                wp <= wdat[0];
                if (wdat[1]) err <= 1'b0;
            end
            if (step) begin
                cnt <= cnt + 1'b1;
                cmp <= (cnt == CNT_MAX);
            end
            if (blk_wr) err <= 1'b1;
            if (cap)    rq  <= ram_rdata;
            if (reg_rd) rq  <= reg_view;
        end
    end

    AST_SECT_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr |=> (cnt == '0)); // R4
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(cmd_wr && wdat[1])) |=> err); // R7
    AST_WRAP_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == CNT_MAX) |=> ($stable(sector) && cnt == '0)); // R5
endmodule

// File: rtl/rdsk_top.sv
`timescale 1ns/1ps
module rdsk_top
    import rdsk_pkg::*;
#(
    parameter int SECT_BITS = 8,
    localparam int AW = SNUM_BITS + SECT_BITS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic          bus_we,
    input  logic [1:0]    bus_reg,
    input  logic [7:0]    bus_wdat,
    output logic          bus_ack,
    output logic [7:0]    bus_rdat,
    output logic [AW-1:0] ram_addr,
    output logic [7:0]    ram_wdata,
    input  logic [7:0]    ram_rdata,
    output logic          ram_we,
    output logic          ram_oe
);
    logic accept, reg_wr, reg_rd, blk_wr, step, cap, wp;
    logic [SNUM_BITS-1:0] sector;
    logic [SECT_BITS-1:0] cnt;

    rdsk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we), .sel(bus_reg),
        .wp(wp), .accept(accept), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .blk_wr(blk_wr), .step(step), .cap(cap), .ram_we(ram_we),
        .ram_oe(ram_oe), .ack(bus_ack)
    );

    rdsk_regs #(.SECT_BITS(SECT_BITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .accept(accept), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .blk_wr(blk_wr), .step(step), .cap(cap),
        .sel(bus_reg), .wdat(bus_wdat), .ram_rdata(ram_rdata),
        .sector(sector), .cnt(cnt), .wp(wp), .wq(ram_wdata), .rq(bus_rdat)
    );

    assign ram_addr = {sector, cnt};

    AST_WE_ONLY_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> !wp); // R6
endmodule

// File: tb/sim_rdsk_top.sv
`timescale 1ns/1ps
module sim_rdsk_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       req [2];
    logic       we  [2];
    logic [1:0] sel [2];
    logic [7:0] wd  [2];
    logic       ack0, ack1, we0, we1, oe0, oe1;
    logic [7:0] rd0, rd1, wdat0, wdat1;
    logic [7:0] rram0 = 8'h00, rram1 = 8'h00;
    logic [23:0] a0;
    logic [24:0] a1;

    logic [7:0] mem0 [int unsigned];
    logic [7:0] mem1 [int unsigned];
    logic [7:0] ref0 [int unsigned];

    int checks = 0, errors = 0;
    bit done = 0;

    rdsk_top u0 (.clk(clk), .rst_n(rst_n), .bus_req(req[0]), .bus_we(we[0]),
        .bus_reg(sel[0]), .bus_wdat(wd[0]), .bus_ack(ack0), .bus_rdat(rd0),
        .ram_addr(a0), .ram_wdata(wdat0), .ram_rdata(rram0), .ram_we(we0), .ram_oe(oe0));
    rdsk_top #(.SECT_BITS(9)) u1 (.clk(clk), .rst_n(rst_n), .bus_req(req[1]), .bus_we(we[1]),
        .bus_reg(sel[1]), .bus_wdat(wd[1]), .bus_ack(ack1), .bus_rdat(rd1),
        .ram_addr(a1), .ram_wdata(wdat1), .ram_rdata(rram1), .ram_we(we1), .ram_oe(oe1));

    always @(posedge clk) begin
        if (we0) mem0[a0] = wdat0;
        if (we1) mem1[a1] = wdat1;
    end
    always @(negedge clk) begin
        rram0 <= mem0.exists(a0) ? mem0[a0] : 8'h00;
        rram1 <= mem1.exists(a1) ? mem1[a1] : 8'h00;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic access(input int w, input bit wr, input logic [1:0] s,
                          input logic [7:0] d, output logic [7:0] q, output int lat);
        @(negedge clk);
        req[w] = 1'b1; we[w] = wr; sel[w] = s; wd[w] = d;
        @(posedge clk);
        @(negedge clk);
        req[w] = 1'b0;
        lat = 1;
        while (!(w == 0 ? ack0 : ack1) && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        q = (w == 0) ? rd0 : rd1;
    endtask

    task automatic set_sector(input int w, input logic [15:0] s);
        logic [7:0] q; int l;
        access(w, 1, 2'd1, s[15:8], q, l);
        access(w, 1, 2'd2, s[7:0], q, l);
    endtask

    function automatic logic [7:0] pat(input int s, input int i);
        return 8'((s * 37) ^ (i * 5) ^ 8'h5A);
    endfunction

    task automatic t_reset;
        logic [7:0] q; int l;
        access(0, 0, 2'd3, 8'h00, q, l);
        chk(q == 8'h00, "R1 reset status", q, 0);
        chk(l == 1, "R8 register latency", l, 1);
        access(0, 0, 2'd1, 8'h00, q, l);
        chk(q == 8'h00, "R1 reset sector high", q, 0);
    endtask

    task automatic t_regmap;
        logic [7:0] q; int l;
        set_sector(0, 16'hA53C);
        access(0, 0, 2'd1, 8'h00, q, l);
        chk(q == 8'hA5, "R1 sector high readback", q, 8'hA5);
        access(0, 0, 2'd2, 8'h00, q, l);
        chk(q == 8'h3C, "R1 sector low readback", q, 8'h3C);
    endtask

    task automatic t_fill(input int s);
        logic [7:0] q; int l; int bad;
        set_sector(0, 16'(s));
        for (int i = 0; i < 256; i++) begin
            access(0, 1, 2'd0, pat(s, i), q, l);
            ref0[{s[15:0], i[7:0]}] = pat(s, i);
            if (i == 0) chk(l == 2, "R8 data write latency", l, 2);
        end
        bad = 0;
        for (int i = 0; i < 256; i++)
            if (!mem0.exists({s[15:0], i[7:0]}) || mem0[{s[15:0], i[7:0]}] != ref0[{s[15:0], i[7:0]}]) bad++;
        chk(bad == 0, "R2 RAM contents at {sector,counter}", bad, 0);
        access(0, 0, 2'd3, 8'h00, q, l);
        chk(q[2] == 1'b1, "R5 sector complete after wrap", q, 8'h04);
    endtask

    task automatic t_readback(input int s);
        logic [7:0] q; int l; int bad;
        set_sector(0, 16'(s));
        bad = 0;
        for (int i = 0; i < 256; i++) begin
            access(0, 0, 2'd0, 8'h00, q, l);
            if (i == 0) chk(l == 2, "R8 data read latency", l, 2);
            if (q != ref0[{s[15:0], i[7:0]}]) bad++;
        end
        chk(bad == 0, "R3 streamed read of sector", bad, 0);
    endtask

    task automatic t_wrap_nocarry;
        logic [7:0] q; int l;
        access(0, 0, 2'd2, 8'h00, q, l);
        chk(q == 8'h02, "R5 no carry into sector", q, 8'h02);
        access(0, 0, 2'd0, 8'h00, q, l);
        chk(q == ref0[{16'd2, 8'd0}], "R5 wrap returns byte 0", q, ref0[{16'd2, 8'd0}]);
        access(0, 0, 2'd3, 8'h00, q, l);
        chk(q[2] == 1'b0, "R5 complete cleared by access", q, 0);
    endtask

    task automatic t_clear;
        logic [7:0] q; int l;
        set_sector(0, 16'd1);
        for (int i = 0; i < 10; i++) access(0, 0, 2'd0, 8'h00, q, l);
        access(0, 1, 2'd2, 8'h01, q, l);
        access(0, 0, 2'd0, 8'h00, q, l);
        chk(q == ref0[{16'd1, 8'd0}], "R4 low write clears counter", q, ref0[{16'd1, 8'd0}]);
        for (int i = 0; i < 5; i++) access(0, 0, 2'd0, 8'h00, q, l);
        access(0, 1, 2'd1, 8'h00, q, l);
        access(0, 0, 2'd0, 8'h00, q, l);
        chk(q == ref0[{16'd1, 8'd0}], "R4 high write clears counter", q, ref0[{16'd1, 8'd0}]);
    endtask

    task automatic t_protect;
        logic [7:0] q; int l;
        access(0, 1, 2'd3, 8'h01, q, l);
        access(0, 0, 2'd3, 8'h00, q, l);
        chk(q[1:0] == 2'b01, "R6 protect bit reads back", q, 8'h01);
        set_sector(0, 16'd1);
        access(0, 1, 2'd0, 8'hEE, q, l);
        chk(l == 1, "R8 protected write latency", l, 1);
        chk(mem0[{16'd1, 8'd0}] == ref0[{16'd1, 8'd0}], "R6 RAM unchanged", mem0[{16'd1, 8'd0}], ref0[{16'd1, 8'd0}]);
        access(0, 0, 2'd0, 8'h00, q, l);
        chk(q == ref0[{16'd1, 8'd1}], "R6 counter advanced", q, ref0[{16'd1, 8'd1}]);
        access(0, 0, 2'd3, 8'h00, q, l);
        chk(q[1] == 1'b1, "R7 error set", q, 8'h03);
        access(0, 1, 2'd3, 8'h00, q, l);
        access(0, 0, 2'd3, 8'h00, q, l);
        chk(q[1:0] == 2'b10, "R7 error sticky after unprotect", q, 8'h02);
        access(0, 1, 2'd3, 8'h02, q, l);
        access(0, 0, 2'd3, 8'h00, q, l);
        chk(q[1:0] == 2'b00, "R7 error cleared", q, 0);
    endtask

    task automatic t_wide;
        logic [7:0] q; int l;
        set_sector(1, 16'd3);
        for (int i = 0; i < 512; i++) begin
            access(1, 1, 2'd0, pat(3, i), q, l);
            if (i == 255) begin
                access(1, 0, 2'd3, 8'h00, q, l);
                chk(q[2] == 1'b0, "R9 no completion at 256", q, 0);
            end
        end
        chk(mem1.exists({16'd3, 9'h1FF}) && mem1[{16'd3, 9'h1FF}] == pat(3, 511),
            "R9 byte 511 address", mem1.exists({16'd3, 9'h1FF}) ? mem1[{16'd3, 9'h1FF}] : 0, pat(3, 511));
        access(1, 0, 2'd3, 8'h00, q, l);
        chk(q[2] == 1'b1, "R9 completion at 512", q, 8'h04);
    endtask

    initial begin
        for (int w = 0; w < 2; w++) begin
            req[w] = 0; we[w] = 0; sel[w] = 0; wd[w] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regmap;
        t_fill(1);
        t_fill(2);
        t_readback(1);
        t_readback(2);
        t_wrap_nocarry;
        t_clear;
        t_protect;
        t_wide;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule